// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer with Trap States

This block is the control sequencer of a processor that runs each instruction over several clock cycles and reuses one ALU and one memory port across those cycles. It supports six instruction kinds: word load, word store, register-register arithmetic, unconditional jump, branch when two registers are equal, and OR with a zero-extended immediate. Each cycle it reads the opcode held in the instruction register and two flags from the datapath (ALU result equal to zero, ALU signed overflow). It then drives the datapath's multiplexer selects, register write enables and ALU operation for that cycle.

Two trap states are added to the basic sequence. If the decode step sees an opcode that belongs to none of the six kinds, the sequencer enters a reserved-opcode trap. If the ALU reports overflow while a register-register instruction executes, it enters an overflow trap instead of writing the result back. Each trap lasts one cycle. In that cycle the sequencer tells the datapath to store the offending instruction's address (PC − 4) in the exception PC register, to record a cause code, and to load PC with the fixed handler address. The next cycle is a fetch.

The datapath, the register file and the memory are outside the block.

Top module: `mc_exc_ctrl`

## Requirements
- R1: In a fetch cycle the block asserts `ir_we` and `mem_re` with `mem_addr_sel`=0 (address from PC). It asserts `pc_we` with `pc_src`=0 (ALU result, which is PC+4 through `alu_a_sel`=0, `alu_b_sel`=1, `alu_op`=0 add). The following cycle is always decode.
- R2: In the decode cycle the block asserts `ab_we`. It dispatches on the opcode: 0x23 load, 0x2B store, 0x00 register-register, 0x02 jump, 0x04 branch-if-equal, 0x0D OR-immediate.
- R3: Any opcode not listed in R2 leads from decode to a one-cycle reserved-opcode trap. In that cycle `epc_we`=1, `cause_we`=1 and `cause_code`=10, so an unlisted opcode takes 3 cycles including fetch.
- R4: If `alu_ovf` is high in the register-register execute cycle, the next cycle is an overflow trap with `cause_code`=12 and no register write. At every other cycle `alu_ovf` has no effect.
- R5: In either trap cycle the block asserts `pc_we` with `pc_src`=3 (handler address). The `epc_we` strobe stores the address of the trapping instruction. The `pc_src` encodings are 0 = ALU result, 1 = branch target, 2 = jump target, 3 = handler.
- R6: A branch-if-equal takes 3 cycles. Its last cycle uses `alu_op`=1 (subtract) and asserts `pc_we` with `pc_src`=1 only when `alu_equal` is high. `alu_equal` has no effect in any other cycle.
- R7: A load takes 5 cycles and ends with `rf_we`, `rf_dst_sel`=0 (rt field) and `rf_wsrc_sel`=1 (memory data). A store takes 4 cycles with one `mem_we`. A register-register instruction takes 4 cycles and writes with `rf_dst_sel`=1 (rd field) and `rf_wsrc_sel`=0 (ALU result). An OR-immediate takes 4 cycles and writes with `rf_dst_sel`=0 and `rf_wsrc_sel`=0.
- R8: An instruction that traps asserts neither `rf_we` nor `mem_we`. In any cycle at most one of `rf_we`, `mem_we`, `epc_we` is high.
- R9: The cycle after a trap cycle is a fetch.
- R10: The reset `rst_n` is synchronous and active low. It places the block in fetch from the next clock edge on, even in the middle of an instruction, and the datapath then fetches from address 0.
- R11: A jump takes 3 cycles. Its last cycle asserts `pc_we` with `pc_src`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | OPW (6) | Opcode field of the instruction register |
| alu_equal | input | 1 | ALU result is zero |
| alu_ovf | input | 1 | ALU signed overflow |
| ir_we | output | 1 | Load instruction register |
| mem_re | output | 1 | Memory read |
| mem_we | output | 1 | Memory write |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| ab_we | output | 1 | Latch the two source operands |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 operand A |
| alu_b_sel | output | 2 | ALU B input: 0 operand B, 1 constant 4, 2 sign-extended immediate, 3 zero-extended immediate |
| alu_op | output | 2 | 0 add, 1 subtract, 2 by function field, 3 OR |
| pc_we | output | 1 | Load PC |
| pc_src | output | 2 | PC source, encoded as in R5 |
| rf_we | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination: 0 rt, 1 rd |
| rf_wsrc_sel | output | 1 | Write data: 0 ALU result, 1 memory data |
| epc_we | output | 1 | Store PC − 4 in the exception PC register |
| cause_we | output | 1 | Write the cause register |
| cause_code | output | CAUSE_W (5) | Cause value, 10 reserved opcode, 12 overflow |

## Verification
The inline properties check the cycle-to-cycle rules on every clock:
- fetch is always followed by decode;
- an unlisted opcode at decode leads to a cause-10 trap;
- overflow in register-register execute leads to a cause-12 trap with no write;
- a trap is followed by fetch;
- a branch write to PC happens only with the equal flag high;
- the three write strobes never overlap.

Some behaviour only the bench's scenarios show, because it needs a datapath model alongside the sequencer:
- the total cycle count of each instruction kind;
- that the exception PC ends up holding the trapping instruction's own address;
- the PC value after each kind;
- that stray `alu_equal` or `alu_ovf` values outside their own cycles change nothing.

// File: rtl/mcx_pkg.sv
// Package: shared state, opcode-class and control-word types for the
// multi-cycle sequencer. Assumes a single clock domain.
package mcx_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MEM_ADDR,
        ST_MEM_RD,
        ST_LOAD_WB,
        ST_MEM_WR,
        ST_R_EXEC,
        ST_R_WB,
        ST_ORI_EXEC,
        ST_ORI_WB,
        ST_BEQ,
        ST_JUMP,
        ST_TRAP_RI,
        ST_TRAP_OVF
    } state_e;

    typedef enum logic [2:0] {
        CLS_LOAD,
        CLS_STORE,
        CLS_RTYPE,
        CLS_JUMP,
        CLS_BEQ,
        CLS_ORI,
        CLS_BAD
    } opclass_e;

    localparam logic [1:0] PCS_ALU     = 2'd0;
    localparam logic [1:0] PCS_BRANCH  = 2'd1;
    localparam logic [1:0] PCS_JUMP    = 2'd2;
    localparam logic [1:0] PCS_HANDLER = 2'd3;

    localparam logic [1:0] ALU_ADD   = 2'd0;
    localparam logic [1:0] ALU_SUB   = 2'd1;
    localparam logic [1:0] ALU_FUNCT = 2'd2;
    localparam logic [1:0] ALU_ORZ   = 2'd3;

    localparam logic [1:0] SRCB_REG  = 2'd0;
    localparam logic [1:0] SRCB_FOUR = 2'd1;
    localparam logic [1:0] SRCB_SEXT = 2'd2;
    localparam logic [1:0] SRCB_ZEXT = 2'd3;

    typedef struct packed {
        logic       ir_we;
        logic       mem_re;
        logic       mem_we;
        logic       mem_addr_sel;
        logic       ab_we;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic       pc_we;
        logic [1:0] pc_src;
        logic       rf_we;
        logic       rf_dst_sel;
        logic       rf_wsrc_sel;
        logic       epc_we;
        logic       cause_we;
    } ctrl_t;

endpackage

// File: rtl/mcx_opclass.sv
// Opcode classifier: maps the raw opcode onto one of the supported
// instruction kinds, or CLS_BAD. Assumes the opcode values are distinct.
module mcx_opclass
    import mcx_pkg::*;
#(
    parameter int          OPW      = 6,
    parameter logic [OPW-1:0] OP_LOAD  = 6'h23,
    parameter logic [OPW-1:0] OP_STORE = 6'h2B,
    parameter logic [OPW-1:0] OP_RTYPE = 6'h00,
    parameter logic [OPW-1:0] OP_JUMP  = 6'h02,
    parameter logic [OPW-1:0] OP_BEQ   = 6'h04,
    parameter logic [OPW-1:0] OP_ORI   = 6'h0D
) (
    input  logic [OPW-1:0] opcode,
    output opclass_e       cls
);

    // Compare the opcode against each supported value.
    always_comb begin
        cls = CLS_BAD;
        if      (opcode == OP_LOAD)  cls = CLS_LOAD;
        else if (opcode == OP_STORE) cls = CLS_STORE;
        else if (opcode == OP_RTYPE) cls = CLS_RTYPE;
        else if (opcode == OP_JUMP)  cls = CLS_JUMP;
        else if (opcode == OP_BEQ)   cls = CLS_BEQ;
        else if (opcode == OP_ORI)   cls = CLS_ORI;
    end

endmodule

// File: rtl/mcx_next.sv
// Next-state logic of the sequencer. Assumes the opcode class is valid
// in decode and the overflow flag is valid in register-register execute.
module mcx_next
    import mcx_pkg::*;
(
    input  state_e   state,
    input  opclass_e cls,
    input  logic     alu_ovf,
    output state_e   nxt
);

    // Choose the successor of the current state.
    always_comb begin
        nxt = ST_FETCH;
        case (state)
            ST_FETCH:    nxt = ST_DECODE;
            ST_DECODE: begin
                case (cls)
                    CLS_LOAD,
                    CLS_STORE: nxt = ST_MEM_ADDR;
                    CLS_RTYPE: nxt = ST_R_EXEC;
                    CLS_ORI:   nxt = ST_ORI_EXEC;
                    CLS_BEQ:   nxt = ST_BEQ;
                    CLS_JUMP:  nxt = ST_JUMP;
                    default:   nxt = ST_TRAP_RI;
                endcase
            end
            ST_MEM_ADDR: nxt = (cls == CLS_LOAD) ? ST_MEM_RD : ST_MEM_WR;
            ST_MEM_RD:   nxt = ST_LOAD_WB;
            ST_R_EXEC:   nxt = alu_ovf ? ST_TRAP_OVF : ST_R_WB;
            ST_ORI_EXEC: nxt = ST_ORI_WB;
            default:     nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcx_outs.sv
// Control-word decoder: drives the datapath controls for the current
// state. Assumes alu_equal reflects the subtraction done in ST_BEQ.
module mcx_outs
    import mcx_pkg::*;
#(
    parameter int CAUSE_W   = 5,
    parameter int CAUSE_RI  = 10,
    parameter int CAUSE_OVF = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  state_e             state,
    input  logic               alu_equal,
    output ctrl_t              ctrl,
    output logic [CAUSE_W-1:0] cause_code
);

    // Build the control word of the current state.
    always_comb begin
        ctrl = '0;
        case (state)
            ST_FETCH: begin
                ctrl.ir_we     = 1'b1;
                ctrl.mem_re    = 1'b1;
                ctrl.alu_b_sel = SRCB_FOUR;
                ctrl.alu_op    = ALU_ADD;
                ctrl.pc_we     = 1'b1;
                ctrl.pc_src    = PCS_ALU;
            end
            ST_DECODE:   ctrl.ab_we = 1'b1;
            ST_MEM_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = SRCB_SEXT;
                ctrl.alu_op    = ALU_ADD;
            end
            ST_MEM_RD: begin
                ctrl.mem_re       = 1'b1;
                ctrl.mem_addr_sel = 1'b1;
            end
            ST_LOAD_WB: begin
                ctrl.rf_we       = 1'b1;
                ctrl.rf_wsrc_sel = 1'b1;
            end
            ST_MEM_WR: begin
                ctrl.mem_we       = 1'b1;
                ctrl.mem_addr_sel = 1'b1;
            end
            ST_R_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = SRCB_REG;
                ctrl.alu_op    = ALU_FUNCT;
            end
            ST_R_WB: begin
                ctrl.rf_we      = 1'b1;
                ctrl.rf_dst_sel = 1'b1;
            end
            ST_ORI_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = SRCB_ZEXT;
                ctrl.alu_op    = ALU_ORZ;
            end
            ST_ORI_WB:   ctrl.rf_we = 1'b1;
            ST_BEQ: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = SRCB_REG;
                ctrl.alu_op    = ALU_SUB;
                ctrl.pc_we     = alu_equal;
                ctrl.pc_src    = PCS_BRANCH;
            end
            ST_JUMP: begin
                ctrl.pc_we  = 1'b1;
                ctrl.pc_src = PCS_JUMP;
            end
            ST_TRAP_RI,
            ST_TRAP_OVF: begin
                ctrl.epc_we   = 1'b1;
                ctrl.cause_we = 1'b1;
                ctrl.pc_we    = 1'b1;
                ctrl.pc_src   = PCS_HANDLER;
            end
            default: ctrl = '0;
        endcase
    end

    // Select the cause value for the trap state in progress.
    always_comb begin
        cause_code = '0;
        if (state == ST_TRAP_RI)  cause_code = CAUSE_W'(CAUSE_RI);
        if (state == ST_TRAP_OVF) cause_code = CAUSE_W'(CAUSE_OVF);
    end

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl.rf_we, ctrl.mem_we, ctrl.epc_we})); // R8

    AST_BRANCH_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_we && ctrl.pc_src == PCS_BRANCH) |-> alu_equal); // R6

endmodule

// File: rtl/mc_exc_ctrl.sv
// Top of the multi-cycle sequencer with reserved-opcode and overflow
// traps. Holds the state register; opcode is the instruction register
// field and is stable from decode to the end of the instruction.
module mc_exc_ctrl
    import mcx_pkg::*;
#(
    parameter int OPW       = 6,
    parameter int CAUSE_W   = 5,
    parameter int CAUSE_RI  = 10,
    parameter int CAUSE_OVF = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPW-1:0]     opcode,
    input  logic               alu_equal,
    input  logic               alu_ovf,
    output logic               ir_we,
    output logic               mem_re,
    output logic               mem_we,
    output logic               mem_addr_sel,
    output logic               ab_we,
    output logic               alu_a_sel,
    output logic [1:0]         alu_b_sel,
    output logic [1:0]         alu_op,
    output logic               pc_we,
    output logic [1:0]         pc_src,
    output logic               rf_we,
    output logic               rf_dst_sel,
    output logic               rf_wsrc_sel,
    output logic               epc_we,
    output logic               cause_we,
    output logic [CAUSE_W-1:0] cause_code
);

    state_e   state_q;
    state_e   state_d;
    opclass_e cls;
    ctrl_t    ctrl;

    mcx_opclass #(.OPW(OPW)) u_cls (
        .opcode (opcode),
        .cls    (cls)
    );

    mcx_next u_next (
        .state   (state_q),
        .cls     (cls),
        .alu_ovf (alu_ovf),
        .nxt     (state_d)
    );

    mcx_outs #(
        .CAUSE_W   (CAUSE_W),
        .CAUSE_RI  (CAUSE_RI),
        .CAUSE_OVF (CAUSE_OVF)
    ) u_outs (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state_q),
        .alu_equal  (alu_equal),
        .ctrl       (ctrl),
        .cause_code (cause_code)
    );

    // State register with synchronous active-low reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Spread the control word onto the output ports.
    always_comb begin
        ir_we        = ctrl.ir_we;
        mem_re       = ctrl.mem_re;
        mem_we       = ctrl.mem_we;
        mem_addr_sel = ctrl.mem_addr_sel;
        ab_we        = ctrl.ab_we;
        alu_a_sel    = ctrl.alu_a_sel;
        alu_b_sel    = ctrl.alu_b_sel;
        alu_op       = ctrl.alu_op;
        pc_we        = ctrl.pc_we;
        pc_src       = ctrl.pc_src;
        rf_we        = ctrl.rf_we;
        rf_dst_sel   = ctrl.rf_dst_sel;
        rf_wsrc_sel  = ctrl.rf_wsrc_sel;
        epc_we       = ctrl.epc_we;
        cause_we     = ctrl.cause_we;
    end

    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |=> ab_we); // R1

    AST_BAD_OPCODE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_we && cls == CLS_BAD) |=> (cause_we && cause_code == CAUSE_W'(CAUSE_RI))); // R3

    AST_OVERFLOW_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_R_EXEC && alu_ovf) |=>
        (epc_we && !rf_we && cause_code == CAUSE_W'(CAUSE_OVF))); // R4

    AST_TRAP_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we |=> (ir_we && !mem_addr_sel)); // R9

    AST_TRAP_TO_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we |-> (pc_we && pc_src == PCS_HANDLER)); // R5

endmodule

// File: tb/sim_mc_exc_ctrl.sv
`timescale 1ns/1ps
module sim_mc_exc_ctrl;

    localparam logic [31:0] HANDLER = 32'h8000_0080;
    localparam logic [31:0] JTARGET = 32'h0000_0100;
    localparam logic [31:0] BR_OFS  = 32'h0000_0020;

    typedef struct packed {
        logic [5:0] op;
        logic       eq;
        logic       ovf;
        logic [3:0] cyc;
        logic       rf;
        logic       dst;
        logic       wsrc;
        logic       mem;
        logic       exc;
        logic [4:0] cause;
        logic [1:0] pcsel;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{6'h23, 1'b0, 1'b0, 4'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  2'd0},
        '{6'h2B, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  2'd0},
        '{6'h00, 1'b0, 1'b0, 4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0},
        '{6'h00, 1'b0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd12, 2'd3},
        '{6'h0D, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0},
        '{6'h0D, 1'b0, 1'b1, 4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0},
        '{6'h04, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  2'd1},
        '{6'h04, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0},
        '{6'h02, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  2'd2},
        '{6'h3F, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd10, 2'd3},
        '{6'h01, 1'b1, 1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd10, 2'd3},
        '{6'h00, 1'b1, 1'b0, 4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  2'd0},
        '{6'h23, 1'b1, 1'b1, 4'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  2'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] opcode;
    logic       alu_equal, alu_ovf;
    logic       ir_we, mem_re, mem_we, mem_addr_sel, ab_we, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op, pc_src;
    logic       pc_we, rf_we, rf_dst_sel, rf_wsrc_sel, epc_we, cause_we;
    logic [4:0] cause_code;

    logic [31:0] pc_m, epc_m;
    logic [4:0]  cause_m;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mc_exc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_equal(alu_equal),
        .alu_ovf(alu_ovf), .ir_we(ir_we), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr_sel(mem_addr_sel), .ab_we(ab_we), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_we(pc_we), .pc_src(pc_src),
        .rf_we(rf_we), .rf_dst_sel(rf_dst_sel), .rf_wsrc_sel(rf_wsrc_sel),
        .epc_we(epc_we), .cause_we(cause_we), .cause_code(cause_code)
    );

    // Behavioural PC, exception PC and cause registers of the datapath.
    always @(posedge clk) begin
        if (!rst_n) begin
            pc_m <= 32'h0;
        end else begin
            if (pc_we) begin
                case (pc_src)
                    2'd0: pc_m <= pc_m + 32'd4;
                    2'd1: pc_m <= pc_m + BR_OFS;
                    2'd2: pc_m <= JTARGET;
                    default: pc_m <= HANDLER;
                endcase
            end
            if (epc_we)   epc_m   <= pc_m - 32'd4;
            if (cause_we) cause_m <= cause_code;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.exc && v.cause == 5'd10) return "R3";
        if (v.exc)                     return "R4";
        if (v.op == 6'h04)             return "R6";
        if (v.op == 6'h02)             return "R11";
        if (v.ovf)                     return "R4";
        if (v.eq)                      return "R6";
        return "R7";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not complete", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        logic [31:0] fa, exp_pc;
        int cyc, nrf, nmem, nexc;
        logic dst, wsrc;
        vec_t v;
        string t;

        rst_n = 1'b0; opcode = 6'h00; alu_equal = 1'b0; alu_ovf = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state is fetch with PC at zero
        chk(ir_we && mem_re && !mem_we && !rf_we && !epc_we, "R10", "fetch during reset",
            {31'h0, ir_we}, 32'h1);
        chk(pc_m == 32'h0, "R10", "pc after reset", pc_m, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            t = tag_of(v);
            fa = pc_m;
            opcode = v.op; alu_equal = v.eq; alu_ovf = v.ovf;
            // R1: fetch cycle controls
            chk(ir_we && mem_re && !mem_addr_sel && pc_we && pc_src == 2'd0 &&
                alu_b_sel == 2'd1 && !alu_a_sel && alu_op == 2'd0,
                "R1", "fetch controls", {30'h0, pc_src}, 32'h0);
            cyc = 1; nrf = 0; nmem = 0; nexc = 0; dst = 1'b0; wsrc = 1'b0;
            while (cyc < 10) begin
                @(negedge clk);
                if (ir_we) break;
                cyc++;
                if (cyc == 2)
                    chk(ab_we, "R2", "decode latches operands", {31'h0, ab_we}, 32'h1);
                if (rf_we) begin nrf++; dst = rf_dst_sel; wsrc = rf_wsrc_sel; end
                if (mem_we) nmem++;
                if (epc_we) nexc++;
            end
            chk(cyc == int'(v.cyc), t, $sformatf("cycles op %0h", v.op), cyc, v.cyc);
            chk(nrf == int'(v.rf), (v.exc ? "R8" : t), "register writes", nrf, v.rf);
            if (v.rf) begin
                chk(dst == v.dst, "R7", "destination select", dst, v.dst);
                chk(wsrc == v.wsrc, "R7", "write source select", wsrc, v.wsrc);
            end
            chk(nmem == int'(v.mem), (v.exc ? "R8" : "R7"), "memory writes", nmem, v.mem);
            chk(nexc == int'(v.exc), t, "trap entries", nexc, v.exc);
            if (v.exc) begin
                chk(cause_m == v.cause, t, "cause code", cause_m, v.cause);
                chk(epc_m == fa, "R5", "exception pc", epc_m, fa);
            end
            case (v.pcsel)
                2'd0: exp_pc = fa + 32'd4;
                2'd1: exp_pc = fa + 32'd4 + BR_OFS;
                2'd2: exp_pc = JTARGET;
                default: exp_pc = HANDLER;
            endcase
            chk(pc_m == exp_pc, (v.exc ? "R5" : t), "next pc", pc_m, exp_pc);
            // R9: after a trap the very next cycle is a fetch
            if (v.exc) chk(ir_we && cyc == 3 + int'(v.op == 6'h00), "R9", "fetch after trap",
                           cyc, 3 + int'(v.op == 6'h00));
        end

        // R10: reset in the middle of a load returns to fetch at address 0
        opcode = 6'h23; alu_equal = 1'b0; alu_ovf = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ir_we && !ab_we && !mem_addr_sel, "R10", "fetch after mid-instruction reset",
            {31'h0, ir_we}, 32'h1);
        chk(pc_m == 32'h0, "R10", "pc after mid-instruction reset", pc_m, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ab_we && !ir_we, "R1", "decode follows fetch", {31'h0, ab_we}, 32'h1);

        finish_run();
    end

endmodule